// File: doc/BRIEF.md
# Block Cipher Register Front End with Block Handshake

This block sits between a 32-bit register bus and a 64-bit block cipher engine. Software loads a key of two or six words, an optional chaining value and a mode word. It then feeds the engine one 64-bit block at a time through a pair of data registers and reads the result back through the same pair. Two ready flags pace the exchange. A data-in event and a data-out event can each raise the interrupt line, and two request lines can pace a DMA engine instead. A length register counts the remaining bytes down as blocks are consumed.

Chaining mode, direction and single or triple key use are applied around a stand-in cipher core. The core has a fixed latency and a simple reversible transform, so the control path can be tested without the round function. Writes are accepted only when they are safe. Configuration and data writes land while no block is in flight and no result is waiting, and any other write to those registers is dropped.

Top module: `des_ctl_top`

## Requirements
- R1: After reset the mode register (0x20) reads 0x2: bit 1 is input-ready and set, and bit 0 is output-ready and clear. The length register (0x24) and the interrupt enable (0x40) read 0, the interrupt line and both DMA requests are low, and from the first clock after reset the status register (0x3C) reads 0x2.
- R2: With bit 4 of 0x20 clear (block-by-block mode), the two words written to 0x28 (upper half) and 0x2C (lower half) form block X. Writing 0x2C starts the core. The result read from 0x28/0x2C is rotl8(X^K) when bit 2 is set (encrypt) and rotr8(X)^K when bit 2 is clear. K = {key word 0, key word 1}, and the key words sit at offsets 0x00 to 0x14.
- R3: With bit 3 of 0x20 set (triple key), K becomes {w0,w1}^{w2,w3}^{w4,w5}.
- R4: With bit 4 set and bit 2 set (chained encrypt), the core input is X^C and the result is its output. The chaining value C is loaded through 0x18 (upper) and 0x1C (lower) and reads back there. C then becomes the result.
- R5: With bit 4 set and bit 2 clear (chained decrypt), the result is the core output XOR C, and C then becomes X.
- R6: While input-ready is low, writes to the key, chaining, mode and data registers are ignored and start no block.
- R7: Input-ready drops when 0x2C is written and stays low until 0x2C is read. Output-ready rises when the core finishes and stays high through a read of 0x28 alone, falling only when 0x2C is read.
- R8: Status bit 1 sets when input-ready rises and bit 2 sets when output-ready rises. Writing 0x3C with 0 in an event bit clears that bit, and writing 1 leaves it unchanged.
- R9: The interrupt line is high exactly when some status bit 1 or 2 is set together with the same bit of the enable register.
- R10: A write to the length register stores the value with its low three bits cleared. Each read of 0x2C that completes a block lowers the length by 8, never below 0.
- R11: The DMA mask register (0x30) uses bit 0 as start, bit 5 as input enable and bit 6 as output enable. The input request is start AND input enable AND input-ready, and the output request is start AND output enable AND output-ready.
- R12: The revision register (0x34) reads the major number in bits 10:8 and the minor number in bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| irq | output | 1 | Combined event interrupt |
| dma_in_req | output | 1 | Request for an input block |
| dma_out_req | output | 1 | Request to drain an output block |

## Verification
The assertions assume that the bus never writes and reads in the same cycle. They also assume that once output-ready is high, the core-done pulse is the only thing that could have raised it, and that nobody writes the length register in the same cycle as a completing read. The stimulus keeps within this: every bus access is a single-cycle transfer issued from a task, and the length is always programmed while the block is idle. Results are polled through the mode register, never timed, so the checks stay valid for any core latency.

// File: rtl/des_ctl_pkg.sv
package des_ctl_pkg;
  localparam int WORD_W    = 32;
  localparam int BLK_W     = 64;
  localparam int KEY_WORDS = 6;
  localparam int ROT       = 8;

  localparam logic [7:0] A_IV_HI  = 8'h18;
  localparam logic [7:0] A_IV_LO  = 8'h1C;
  localparam logic [7:0] A_CTRL   = 8'h20;
  localparam logic [7:0] A_LEN    = 8'h24;
  localparam logic [7:0] A_DAT_HI = 8'h28;
  localparam logic [7:0] A_DAT_LO = 8'h2C;
  localparam logic [7:0] A_DMA    = 8'h30;
  localparam logic [7:0] A_REV    = 8'h34;
  localparam logic [7:0] A_IRQ_ST = 8'h3C;
  localparam logic [7:0] A_IRQ_EN = 8'h40;

  localparam int B_CBC = 4;
  localparam int B_TDES = 3;
  localparam int B_ENC = 2;
  localparam int B_EVT_IN = 1;
  localparam int B_EVT_OUT = 2;
  localparam int B_DMA_GO = 0;
  localparam int B_DMA_IN = 5;
  localparam int B_DMA_OUT = 6;

  function automatic logic [BLK_W-1:0] key_mix(
      input logic [KEY_WORDS*WORD_W-1:0] kw, input logic tdes);
    logic [BLK_W-1:0] m;
    m = {kw[0*WORD_W +: WORD_W], kw[1*WORD_W +: WORD_W]};
    if (tdes)
      m = m ^ {kw[2*WORD_W +: WORD_W], kw[3*WORD_W +: WORD_W]}
            ^ {kw[4*WORD_W +: WORD_W], kw[5*WORD_W +: WORD_W]};
    return m;
  endfunction

  function automatic logic [BLK_W-1:0] stub_enc(
      input logic [BLK_W-1:0] x, input logic [BLK_W-1:0] k);
    logic [BLK_W-1:0] t;
    t = x ^ k;
    return {t[BLK_W-ROT-1:0], t[BLK_W-1 -: ROT]};
  endfunction

  function automatic logic [BLK_W-1:0] stub_dec(
      input logic [BLK_W-1:0] y, input logic [BLK_W-1:0] k);
    return {y[ROT-1:0], y[BLK_W-1:ROT]} ^ k;
  endfunction

  function automatic logic [WORD_W-1:0] len_after_block(input logic [WORD_W-1:0] l);
    return (l >= WORD_W'(8)) ? l - WORD_W'(8) : '0;
  endfunction
endpackage

// File: rtl/des_stub_core.sv
module des_stub_core
  import des_ctl_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BLK_W-1:0] blk_in,
  input  logic [BLK_W-1:0] mix_key,
  input  logic             enc,
  output logic             busy,
  output logic             done,
  output logic [BLK_W-1:0] blk_out
);
  localparam int CNT_W = (LAT > 1) ? $clog2(LAT + 1) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [BLK_W-1:0] dat_q, key_q;
  logic             enc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      dat_q <= '0;
      key_q <= '0;
      enc_q <= 1'b0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= CNT_W'(LAT - 1);
      dat_q <= blk_in;
      key_q <= mix_key;
      enc_q <= enc;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done    = busy && (cnt_q == '0);
  assign blk_out = enc_q ? stub_enc(dat_q, key_q) : stub_dec(dat_q, key_q);
endmodule

// File: rtl/des_chain.sv
module des_chain
  import des_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iv_we_hi,
  input  logic              iv_we_lo,
  input  logic [WORD_W-1:0] wdata,
  input  logic              cbc,
  input  logic              enc,
  input  logic              start,
  input  logic [BLK_W-1:0]  blk_in,
  input  logic              done,
  input  logic [BLK_W-1:0]  core_out,
  output logic [BLK_W-1:0]  core_in,
  output logic [BLK_W-1:0]  blk_res,
  output logic [BLK_W-1:0]  chain
);
  logic [BLK_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain  <= '0;
      held_q <= '0;
    end else begin
      if (start) held_q <= blk_in;
      if (iv_we_hi) chain[BLK_W-1 -: WORD_W] <= wdata;
      if (iv_we_lo) chain[WORD_W-1:0]        <= wdata;
      if (done && cbc) chain <= enc ? core_out : held_q;
    end
  end

  assign core_in = (cbc && enc)  ? (blk_in ^ chain)   : blk_in;
  assign blk_res = (cbc && !enc) ? (core_out ^ chain) : core_out;
endmodule

// File: rtl/des_ctl_top.sv
module des_ctl_top
  import des_ctl_pkg::*;
#(
  parameter int LAT       = 4,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        dma_in_req,
  output logic        dma_out_req
);
  logic wr_en, rd_en, cfg_we, in_rdy, out_rdy, in_rdy_d, out_rdy_d;
  logic evt_in, evt_out, start, blk_take, st_we, len_we, key0_busy_wr;
  logic cbc_q, tdes_q, enc_q;
  logic [2:1] st_q, en_q;
  logic [2:0] dma_q;
  logic [WORD_W-1:0] len_q, din_hi_q;
  logic [WORD_W-1:0] key_q [KEY_WORDS];
  logic [KEY_WORDS*WORD_W-1:0] key_flat;
  logic [BLK_W-1:0] res_q, core_in, core_out, blk_res, chain;
  logic core_busy, core_done;

  assign wr_en  = bus_sel && bus_wr;
  assign rd_en  = bus_sel && !bus_wr;
  assign in_rdy = !core_busy && !out_rdy;
  assign cfg_we = wr_en && in_rdy;
  assign start  = cfg_we && (bus_addr == A_DAT_LO);
  assign blk_take = rd_en && (bus_addr == A_DAT_LO) && out_rdy;
  assign st_we  = wr_en && (bus_addr == A_IRQ_ST);
  assign len_we = wr_en && (bus_addr == A_LEN);
  assign key0_busy_wr = wr_en && !in_rdy && (bus_addr == 8'h00);
  assign evt_in  = in_rdy && !in_rdy_d;
  assign evt_out = out_rdy && !out_rdy_d;

  for (genvar i = 0; i < KEY_WORDS; i++) begin : g_key
    always_ff @(posedge clk) begin
      if (!rst_n) key_q[i] <= '0;
      else if (cfg_we && bus_addr == 8'(4 * i)) key_q[i] <= bus_wdata;
    end
    assign key_flat[i*WORD_W +: WORD_W] = key_q[i];
  end

  des_chain u_chain (
    .clk(clk), .rst_n(rst_n),
    .iv_we_hi(cfg_we && bus_addr == A_IV_HI),
    .iv_we_lo(cfg_we && bus_addr == A_IV_LO),
    .wdata(bus_wdata), .cbc(cbc_q), .enc(enc_q),
    .start(start), .blk_in({din_hi_q, bus_wdata}),
    .done(core_done), .core_out(core_out),
    .core_in(core_in), .blk_res(blk_res), .chain(chain)
  );

  des_stub_core #(.LAT(LAT)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_in(core_in),
    .mix_key(key_mix(key_flat, tdes_q)), .enc(enc_q),
    .busy(core_busy), .done(core_done), .blk_out(core_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {cbc_q, tdes_q, enc_q} <= '0;
      din_hi_q <= '0;
      res_q    <= '0;
      out_rdy  <= 1'b0;
      in_rdy_d <= 1'b0;
      out_rdy_d <= 1'b0;
      len_q    <= '0;
      dma_q    <= '0;
      st_q     <= '0;
      en_q     <= '0;
    end else begin
      in_rdy_d  <= in_rdy;
      out_rdy_d <= out_rdy;
      if (cfg_we && bus_addr == A_CTRL)
        {cbc_q, tdes_q, enc_q} <= {bus_wdata[B_CBC], bus_wdata[B_TDES], bus_wdata[B_ENC]};
      if (cfg_we && bus_addr == A_DAT_HI) din_hi_q <= bus_wdata;
      if (core_done) begin
        res_q   <= blk_res;
        out_rdy <= 1'b1;
      end else if (blk_take) begin
        out_rdy <= 1'b0;
      end
      if (len_we)        len_q <= {bus_wdata[WORD_W-1:3], 3'b000};
      else if (blk_take) len_q <= len_after_block(len_q);
      if (wr_en && bus_addr == A_DMA)
        dma_q <= {bus_wdata[B_DMA_OUT], bus_wdata[B_DMA_IN], bus_wdata[B_DMA_GO]};
      if (wr_en && bus_addr == A_IRQ_EN)
        en_q <= {bus_wdata[B_EVT_OUT], bus_wdata[B_EVT_IN]};
      st_q[B_EVT_IN]  <= evt_in  || (st_q[B_EVT_IN]  && !(st_we && !bus_wdata[B_EVT_IN]));
      st_q[B_EVT_OUT] <= evt_out || (st_q[B_EVT_OUT] && !(st_we && !bus_wdata[B_EVT_OUT]));
    end
  end

  assign irq         = |(st_q & en_q);
  assign dma_in_req  = dma_q[0] && dma_q[1] && in_rdy;
  assign dma_out_req = dma_q[0] && dma_q[2] && out_rdy;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_IV_HI:  bus_rdata = chain[BLK_W-1 -: WORD_W];
      A_IV_LO:  bus_rdata = chain[WORD_W-1:0];
      A_CTRL:   bus_rdata = {27'b0, cbc_q, tdes_q, enc_q, in_rdy, out_rdy};
      A_LEN:    bus_rdata = len_q;
      A_DAT_HI: bus_rdata = res_q[BLK_W-1 -: WORD_W];
      A_DAT_LO: bus_rdata = res_q[WORD_W-1:0];
      A_DMA:    bus_rdata = {25'b0, dma_q[2], dma_q[1], 4'b0, dma_q[0]};
      A_REV:    bus_rdata = {21'b0, 3'(REV_MAJOR), 2'b0, 6'(REV_MINOR)};
      A_IRQ_ST: bus_rdata = {29'b0, st_q, 1'b0};
      A_IRQ_EN: bus_rdata = {29'b0, en_q, 1'b0};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/des_ctl_chk.sv
module des_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_rdy,
  input logic        out_rdy,
  input logic        core_done,
  input logic        irq,
  input logic [1:0]  irq_en,
  input logic        st_in,
  input logic [31:0] len_q,
  input logic        blk_take,
  input logic        len_we,
  input logic [31:0] key0,
  input logic        key0_busy_wr,
  input logic        dma_out_req
);
  // R7
  out_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_rdy) |-> $past(core_done));
  // R8
  in_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_rdy) |=> st_in);
  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 2'b00) |-> !irq);
  // R10
  len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_take && !len_we && len_q >= 32'd8) |=> (len_q == $past(len_q) - 32'd8));
  // R6
  key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key0_busy_wr |=> $stable(key0));
  // R11
  dma_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_out_req |-> out_rdy);
endmodule

bind des_ctl_top des_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_rdy(in_rdy), .out_rdy(out_rdy),
  .core_done(core_done), .irq(irq), .irq_en(en_q), .st_in(st_q[1]),
  .len_q(len_q), .blk_take(blk_take), .len_we(len_we), .key0(key_q[0]),
  .key0_busy_wr(key0_busy_wr), .dma_out_req(dma_out_req)
);

// File: tb/sim_des_ctl_top.sv
`timescale 1ns/1ps
module sim_des_ctl_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, dma_in_req, dma_out_req;
  int errors = 0, checks = 0;
  bit reported = 0;

  always #5 clk = ~clk;

  des_ctl_top u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .dma_in_req(dma_in_req), .dma_out_req(dma_out_req));

  // vector: [67] reload chain, [66] chained, [65] triple key, [64] encrypt, [63:0] block
  localparam logic [67:0] VEC [8] = '{
    {4'b0001, 64'h0123_4567_89AB_CDEF},
    {4'b0000, 64'hFEDC_BA98_7654_3210},
    {4'b0011, 64'h0000_0000_0000_0001},
    {4'b0010, 64'hFFFF_FFFF_FFFF_FFFF},
    {4'b1101, 64'h1122_3344_5566_7788},
    {4'b0101, 64'h1122_3344_5566_7788},
    {4'b1100, 64'hDEAD_BEEF_0BAD_F00D},
    {4'b0110, 64'h0F0F_0F0F_F0F0_F0F0}
  };
  localparam logic [63:0] IVC = 64'h0A1B_2C3D_4E5F_6071;

  logic [31:0] kw [6];
  logic [63:0] chain_m;

  function automatic logic [63:0] m_key(input logic tdes);
    logic [63:0] k = {kw[0], kw[1]};
    if (tdes) k = k ^ {kw[2], kw[3]} ^ {kw[4], kw[5]};
    return k;
  endfunction
  function automatic logic [63:0] m_enc(input logic [63:0] x, input logic [63:0] k);
    logic [63:0] t = x ^ k;
    return (t << 8) | (t >> 56);
  endfunction
  function automatic logic [63:0] m_dec(input logic [63:0] y, input logic [63:0] k);
    return ((y >> 8) | (y << 56)) ^ k;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic wait_out();
    logic [31:0] c;
    for (int n = 0; n < 50; n++) begin
      rd(8'h20, c);
      if (c[0]) break;
    end
  endtask

  task automatic run_block(input logic [4:0] mode, input logic [63:0] b, output logic [63:0] r);
    logic [31:0] h, l;
    wr(8'h20, {27'b0, mode});
    wr(8'h28, b[63:32]);
    wr(8'h2C, b[31:0]);
    wait_out();
    rd(8'h28, h);
    rd(8'h2C, l);
    r = {h, l};
  endtask

  task automatic finish_up();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [31:0] d, h;
    logic [63:0] r, e, k;
    for (int i = 0; i < 6; i++) kw[i] = 32'h0103_0507 * (i + 3) ^ 32'hA5C3_3C5A;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    rd(8'h20, d); chk("R1 ctrl", d, 32'h2);
    rd(8'h24, d); chk("R1 length", d, 0);
    rd(8'h40, d); chk("R1 enable", d, 0);
    rd(8'h3C, d); chk("R1 status", d, 32'h2);
    chk("R1 outputs", {irq, dma_in_req, dma_out_req}, 0);
    // R12 revision
    rd(8'h34, d); chk("R12 revision", d, 32'h0000_0205);

    for (int i = 0; i < 6; i++) wr(8'(4 * i), kw[i]);
    chain_m = 0;
    foreach (VEC[i]) begin
      logic [3:0] f = VEC[i][67:64];
      logic [63:0] b = VEC[i][63:0];
      string tag;
      if (f[3]) begin
        wr(8'h18, IVC[63:32]); wr(8'h1C, IVC[31:0]); chain_m = IVC;
      end
      k = m_key(f[1]);
      if (!f[2]) e = f[0] ? m_enc(b, k) : m_dec(b, k);
      else if (f[0]) begin e = m_enc(b ^ chain_m, k); chain_m = e; end
      else begin e = m_dec(b, k) ^ chain_m; chain_m = b; end
      tag = f[2] ? (f[0] ? "R4 chained encrypt" : "R5 chained decrypt")
                 : (f[1] ? "R3 triple key" : "R2 block mode");
      run_block({f[2], f[1], f[0], 2'b00}, b, r);
      chk(tag, r, e);
      if (f[2]) begin
        rd(8'h18, d); rd(8'h1C, h);
        chk(f[0] ? "R4 chain update" : "R5 chain update", {d, h}, chain_m);
      end
    end

    // R7 handshake
    wr(8'h20, 32'h04);
    wr(8'h28, 32'h1234_5678);
    wr(8'h2C, 32'h9ABC_DEF0);
    rd(8'h20, d); chk("R7 busy flags", d, 32'h04);
    wait_out();
    rd(8'h28, h);
    rd(8'h20, d); chk("R7 out held after upper read", d, 32'h05);
    rd(8'h2C, d);
    chk("R7 result", {h, d}, m_enc(64'h1234_5678_9ABC_DEF0, m_key(0)));
    rd(8'h20, d); chk("R7 input ready back", d, 32'h06);

    // R6 ignored writes while not ready
    wr(8'h28, 32'h0000_0001);
    wr(8'h2C, 32'h0000_0002);
    wait_out();
    wr(8'h00, 32'hDEAD_0000);
    wr(8'h20, 32'h1C);
    wr(8'h1C, 32'h5555_5555);
    wr(8'h2C, 32'h7777_7777);
    rd(8'h20, d); chk("R6 mode unchanged", d, 32'h05);
    rd(8'h28, h); rd(8'h2C, d);
    chk("R6 result intact", {h, d}, m_enc(64'h1_0000_0002, m_key(0)));
    rd(8'h20, d); chk("R6 no extra block", d, 32'h06);
    rd(8'h1C, d); chk("R6 chain unchanged", d, chain_m[31:0]);
    run_block(5'b00100, 64'h0000_0003_0000_0004, r);
    chk("R6 key unchanged", r, m_enc(64'h0000_0003_0000_0004, m_key(0)));

    // R10 length
    wr(8'h24, 32'h13);
    rd(8'h24, d); chk("R10 low bits cleared", d, 32'h10);
    run_block(5'b00100, 64'h5, r);
    rd(8'h24, d); chk("R10 first step", d, 32'h8);
    run_block(5'b00100, 64'h6, r);
    rd(8'h24, d); chk("R10 reaches zero", d, 0);
    run_block(5'b00100, 64'h7, r);
    rd(8'h24, d); chk("R10 floor at zero", d, 0);

    // R8 / R9 events and interrupt
    wr(8'h40, 0);
    wr(8'h3C, 0);
    rd(8'h3C, d); chk("R8 write zero clears", d, 0);
    chk("R9 irq low", irq, 0);
    wr(8'h40, 32'h2);
    chk("R9 enabled but no event", irq, 0);
    run_block(5'b00100, 64'h8, r);
    rd(8'h3C, d); chk("R8 both events", d, 32'h6);
    chk("R9 irq on input event", irq, 1);
    wr(8'h3C, 32'h4);
    rd(8'h3C, d); chk("R8 one keeps bit", d, 32'h4);
    chk("R9 irq masked", irq, 0);
    wr(8'h40, 32'h4);
    chk("R9 irq on output event", irq, 1);
    wr(8'h40, 0);
    chk("R9 irq disabled", irq, 0);

    // R11 DMA requests
    wr(8'h30, 32'h21);
    chk("R11 input request idle", {dma_in_req, dma_out_req}, 2'b10);
    wr(8'h30, 32'h61);
    wr(8'h28, 32'h1); wr(8'h2C, 32'h2);
    wait_out();
    chk("R11 output request", {dma_in_req, dma_out_req}, 2'b01);
    rd(8'h28, h); rd(8'h2C, d);
    wr(8'h30, 32'h60);
    chk("R11 stopped", {dma_in_req, dma_out_req}, 2'b00);

    finish_up();
  end
endmodule